// File: doc/BRIEF.md
# Radio Configuration Word Sequencer

This block programs a radio transceiver through a three-wire control port made of a serial data line, a serial clock and a latch strobe. Each 32-bit control word is shifted out most significant bit first. Data is presented while the clock is low, and the clock then rises. After the last bit the block can raise a latch strobe, which commits the word inside the transceiver.

A start command issues a fixed programming sequence of fourteen words. Most words come in on input ports. Five constant words are parameters. The register-2 word is assembled from an input word and a six-bit power level. A calibration wait is placed after the fifth word. A separate single-word command shifts one arbitrary word and can skip the latch, so that a later command can commit it. The shift path is shared by both transceivers of a duplex pair. A target-select input, sampled when a command is accepted, picks which of the two latch outputs fires.

Top module: `radio_cfg_seq`

## Requirements
- R1: Each word is shifted as 32 bits, bit 31 first. Every bit is stable on `ser_data` for the whole time `ser_clk` is high.
- R2: Inside a word, `ser_clk` stays low for exactly BIT_CYC cycles before each rise and stays high for exactly BIT_CYC cycles.
- R3: `ser_data` is low whenever no bit is being presented: when idle, during a latch pulse and during the calibration wait.
- R4: When the latch is requested, one latch output goes high on the same edge where the clock falls after bit 0, and it stays high for BIT_CYC cycles. A single-word command with `wr_latch`=0 produces no latch pulse.
- R5: The start command sends words for registers 1, 3, 4, 6, 5, then 0, 2, 14, 9, 10, 11, 12, 13, 15, in that order, with every word latched. Register 14 is DAC_WORD (default 0x0000000E), register 9 is AGC_WORD (0x000231E9), register 11 is SYNC_WORD (0x0000003B), register 12 is THR_WORD (0x0000010C) and register 15 is TEST_WORD (0x000E000F).
- R6: The register-2 word sent is `r2_word` with bits 3:0 replaced by 0b0010. The value (`pa_level` << 13) and the value (0b110001 << 7) are ORed into it.
- R7: From the fall of the register-5 latch to the first clock rise of the register-0 word there are CAL_CYC+BIT_CYC cycles. Between any other two words of the sequence the gap is BIT_CYC cycles.
- R8: `tgt_sel`=0 at command acceptance selects `latch_a` and `tgt_sel`=1 selects `latch_b`. The other latch output stays low, and the two are never high together.
- R9: `busy` is high from the cycle after a command is accepted until the final latch pulse (or final bit) completes. `done` is a single-cycle pulse in the first cycle after `busy` falls.
- R10: `start` and `wr_go` are ignored while `busy` is high. When both are asserted in the same idle cycle, `start` wins.
- R11: While reset is held, and after reset, every output is low. A reset in the middle of a transfer aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the full programming sequence |
| wr_go | input | 1 | Begin a single-word write |
| wr_word | input | 32 | Word for the single-word write |
| wr_latch | input | 1 | Latch after the single word (0 = skip latch) |
| tgt_sel | input | 1 | Latch target: 0 = latch_a, 1 = latch_b |
| r1_word | input | 32 | Register 1 word (oscillator) |
| r3_word | input | 32 | Register 3 word (clocking) |
| r4_word | input | 32 | Register 4 word (demodulator) |
| r6_word | input | 32 | Register 6 word (fine filter calibration) |
| r5_word | input | 32 | Register 5 word (coarse filter calibration) |
| r0_word | input | 32 | Register 0 word (frequency) |
| r2_word | input | 32 | Register 2 base word (modulation) |
| pa_level | input | 6 | Power level merged into register 2 |
| r10_word | input | 32 | Register 10 word (frequency control) |
| r13_word | input | 32 | Register 13 word (slicer) |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Serial clock |
| latch_a | output | 1 | Latch strobe, first transceiver |
| latch_b | output | 1 | Latch strobe, second transceiver |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle. The two latch outputs are never high together. Data does not move while the clock is high. Data, clock and latches are all quiet when idle. A latch only rises as the clock falls. `done` is one cycle long and comes right after `busy` drops. Other behaviour shows only in the bench's scenarios: the exact word order and contents, the register-2 assembly, the exact clock and latch widths, the length of the calibration gap, and the ignoring of commands while busy.

// File: rtl/radio_cfg_seq.sv
module radio_cfg_seq #(
  parameter int          BIT_CYC   = 4,
  parameter int          CAL_CYC   = 100,
  parameter logic [31:0] DAC_WORD  = 32'h0000_000E,
  parameter logic [31:0] AGC_WORD  = 32'h0002_31E9,
  parameter logic [31:0] SYNC_WORD = 32'h0000_003B,
  parameter logic [31:0] THR_WORD  = 32'h0000_010C,
  parameter logic [31:0] TEST_WORD = 32'h000E_000F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr_go,
  input  logic [31:0] wr_word,
  input  logic        wr_latch,
  input  logic        tgt_sel,
  input  logic [31:0] r1_word,
  input  logic [31:0] r3_word,
  input  logic [31:0] r4_word,
  input  logic [31:0] r6_word,
  input  logic [31:0] r5_word,
  input  logic [31:0] r0_word,
  input  logic [31:0] r2_word,
  input  logic [5:0]  pa_level,
  input  logic [31:0] r10_word,
  input  logic [31:0] r13_word,
  output logic        ser_data,
  output logic        ser_clk,
  output logic        latch_a,
  output logic        latch_b,
  output logic        busy,
  output logic        done
);

  localparam int NSLOT    = 14;
  localparam int CAL_SLOT = 4;
  localparam int CNT_MAX  = (BIT_CYC > CAL_CYC) ? BIT_CYC : CAL_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [3:0]  LAST_SLOT = 4'(NSLOT - 1);
  localparam logic [31:0] PA_CONST  = 32'(6'b110001) << 7;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LATCH, S_WAIT} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [4:0]  bitn;
  logic [3:0]  slot;
  logic [31:0] sh;
  logic        sel_q, single_q, latch_q, done_q;
  logic [31:0] r2_full, nxt_word;
  logic [3:0]  nxt_slot;
  logic        tick, wait_end, word_end;

  assign r2_full  = {r2_word[31:4], 4'b0010} | (32'(pa_level) << 13) | PA_CONST;
  assign nxt_slot = slot + 4'd1;
  assign tick     = (cnt == CW'(BIT_CYC - 1));
  assign wait_end = (cnt == CW'(CAL_CYC - 1));
  assign word_end = ((st == S_HIGH) && tick && (bitn == 5'd31) && !latch_q) ||
                    ((st == S_LATCH) && tick);

  always_comb begin
    case (nxt_slot)
      4'd1:    nxt_word = r3_word;
      4'd2:    nxt_word = r4_word;
      4'd3:    nxt_word = r6_word;
      4'd4:    nxt_word = r5_word;
      4'd5:    nxt_word = r0_word;
      4'd6:    nxt_word = r2_full;
      4'd7:    nxt_word = DAC_WORD;
      4'd8:    nxt_word = AGC_WORD;
      4'd9:    nxt_word = r10_word;
      4'd10:   nxt_word = SYNC_WORD;
      4'd11:   nxt_word = THR_WORD;
      4'd12:   nxt_word = r13_word;
      4'd13:   nxt_word = TEST_WORD;
      default: nxt_word = r1_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      slot     <= '0;
      sh       <= '0;
      sel_q    <= 1'b0;
      single_q <= 1'b0;
      latch_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt  <= '0;
          bitn <= '0;
          if (start) begin
            sel_q    <= tgt_sel;
            single_q <= 1'b0;
            latch_q  <= 1'b1;
            slot     <= '0;
            sh       <= r1_word;
            st       <= S_SETUP;
          end else if (wr_go) begin
            sel_q    <= tgt_sel;
            single_q <= 1'b1;
            latch_q  <= wr_latch;
            sh       <= wr_word;
            st       <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (tick) begin
            cnt <= '0;
            st  <= S_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (!tick) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (bitn != 5'd31) begin
              bitn <= bitn + 5'd1;
              sh   <= sh << 1;
              st   <= S_SETUP;
            end else begin
              bitn <= '0;
              if (latch_q) st <= S_LATCH;
            end
          end
        end
        S_LATCH: begin
          if (!tick) cnt <= cnt + 1'b1;
          else cnt <= '0;
        end
        S_WAIT: begin
          if (wait_end) begin
            cnt  <= '0;
            slot <= nxt_slot;
            sh   <= nxt_word;
            st   <= S_SETUP;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase

      if (word_end) begin
        if (single_q || slot == LAST_SLOT) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else if (slot == 4'(CAL_SLOT)) begin
          st <= S_WAIT;
        end else begin
          slot <= nxt_slot;
          sh   <= nxt_word;
          st   <= S_SETUP;
        end
      end
    end
  end

  assign ser_clk  = (st == S_HIGH);
  assign ser_data = ((st == S_SETUP) || (st == S_HIGH)) && sh[31];
  assign latch_a  = (st == S_LATCH) && !sel_q;
  assign latch_b  = (st == S_LATCH) && sel_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_a && latch_b)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data && !latch_a && !latch_b)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R1
  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_a || latch_b) |-> $fell(ser_clk)); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

endmodule

// File: tb/radio_cfg_seq_tb.sv
module radio_cfg_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int BITC  = 4;
  localparam int CALC  = 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_go = 1'b0, wr_latch = 1'b0, tgt_sel = 1'b0;
  logic [31:0] wr_word = '0;
  logic [31:0] r1 = 32'hA100_0001, r3 = 32'hA300_0003, r4 = 32'hA400_0004, r6 = 32'hA600_0006;
  logic [31:0] r5 = 32'hA500_0005, r0 = 32'h5800_1230, r2 = 32'h1234_567F;
  logic [31:0] r10 = 32'hAA00_000A, r13 = 32'hAD00_000D;
  logic [5:0]  pa = 6'h2A;
  logic ser_data, ser_clk, latch_a, latch_b, busy, done;

  radio_cfg_seq #(.BIT_CYC(BITC), .CAL_CYC(CALC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_go(wr_go), .wr_word(wr_word),
    .wr_latch(wr_latch), .tgt_sel(tgt_sel), .r1_word(r1), .r3_word(r3), .r4_word(r4),
    .r6_word(r6), .r5_word(r5), .r0_word(r0), .r2_word(r2), .pa_level(pa),
    .r10_word(r10), .r13_word(r13), .ser_data(ser_data), .ser_clk(ser_clk),
    .latch_a(latch_a), .latch_b(latch_b), .busy(busy), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int nbits, cap_n, la_n, lb_n, done_n, hi_bad, lo_bad, lw_bad, lpos_bad, idle_bad;
  int t_rise, t_fall, t_lrise, t_lfall;
  logic [31:0] sh_in;
  logic [31:0] caps [0:15];
  int gaps [0:15];

  localparam logic [33:0] VEC [4] = '{
    {32'h8000_0001, 1'b1, 1'b0},
    {32'h5A5A_A5A5, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 1'b0, 1'b0},
    {32'h0000_0000, 1'b1, 1'b0}
  };

  always @(negedge clk) begin
    cyc++;
    if (done) done_n++;
    if (!busy && ser_data) idle_bad++;
    if ((latch_a || latch_b) && ser_data) idle_bad++;
  end

  always @(posedge ser_clk) begin
    if (nbits % 32 == 0) gaps[cap_n] = cyc - t_lfall;
    else if (cyc - t_fall != BITC) lo_bad++;
    sh_in = {sh_in[30:0], ser_data};
    nbits++;
    t_rise = cyc;
    if (nbits % 32 == 0) begin
      caps[cap_n] = sh_in;
      cap_n++;
    end
  end

  always @(negedge ser_clk) begin
    t_fall = cyc;
    if (cyc - t_rise != BITC) hi_bad++;
  end

  always @(posedge latch_a) begin la_n++; t_lrise = cyc; if (nbits % 32 != 0) lpos_bad++; end
  always @(posedge latch_b) begin lb_n++; t_lrise = cyc; if (nbits % 32 != 0) lpos_bad++; end
  always @(negedge latch_a or negedge latch_b) begin
    if (rst_n) begin
      t_lfall = cyc;
      if (t_lfall - t_lrise != BITC) lw_bad++;
      if (t_lrise != t_fall) lpos_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    nbits = 0; cap_n = 0; la_n = 0; lb_n = 0; done_n = 0;
    hi_bad = 0; lo_bad = 0; lw_bad = 0; lpos_bad = 0; idle_bad = 0;
    t_rise = 0; t_fall = 0; t_lrise = 0; t_lfall = cyc; sh_in = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_n > 0) break;
    end
    @(negedge clk);
  endtask

  logic [31:0] expw [0:13];

  initial begin
    expw[0] = r1;  expw[1] = r3;  expw[2] = r4;  expw[3] = r6;  expw[4] = r5;
    expw[5] = r0;
    expw[6] = {r2[31:4], 4'b0010} | (32'(pa) << 13) | (32'h31 << 7);
    expw[7] = 32'h0000_000E; expw[8] = 32'h0002_31E9; expw[9] = r10;
    expw[10] = 32'h0000_003B; expw[11] = 32'h0000_010C; expw[12] = r13;
    expw[13] = 32'h000E_000F;
    clr();

    repeat (3) @(negedge clk);
    chk(!ser_data && !ser_clk && !latch_a && !latch_b && !busy && !done, "R11 reset outputs",
        {26'b0, ser_data, ser_clk, latch_a, latch_b, busy, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !ser_clk, "R11 idle after reset", {31'b0, busy}, 32'h0);

    for (int v = 0; v < 4; v++) begin
      clr();
      wr_word = VEC[v][33:2]; wr_latch = VEC[v][1]; tgt_sel = VEC[v][0]; wr_go = 1'b1;
      @(negedge clk); wr_go = 1'b0;
      chk(busy, "R9 busy after accept", {31'b0, busy}, 32'h1);
      wait_done();
      chk(cap_n == 1 && caps[0] == VEC[v][33:2], "R1 single word", caps[0], VEC[v][33:2]);
      chk(hi_bad == 0 && lo_bad == 0, "R2 clock widths", hi_bad + lo_bad, 0);
      chk(la_n == int'(VEC[v][1] && !VEC[v][0]), "R4/R8 latch_a count", la_n, int'(VEC[v][1] && !VEC[v][0]));
      chk(lb_n == int'(VEC[v][1] && VEC[v][0]), "R4/R8 latch_b count", lb_n, int'(VEC[v][1] && VEC[v][0]));
      chk(lw_bad == 0 && lpos_bad == 0, "R4 latch width/position", lw_bad + lpos_bad, 0);
      chk(done_n == 1 && !busy, "R9 done pulse", done_n, 1);
    end

    clr();
    tgt_sel = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(cap_n == 14, "R5 word count", cap_n, 14);
    for (int k = 0; k < 14; k++) begin
      if (k == 6) chk(caps[k] == expw[k], "R6 register-2 word", caps[k], expw[k]);
      else chk(caps[k] == expw[k], "R5 sequence word", caps[k], expw[k]);
    end
    chk(la_n == 14 && lb_n == 0, "R8 all latches on a", la_n, 14);
    chk(gaps[5] == CALC + BITC, "R7 calibration gap", gaps[5], CALC + BITC);
    chk(gaps[6] == BITC && gaps[3] == BITC, "R7 normal gap", gaps[6], BITC);
    chk(hi_bad == 0 && lo_bad == 0 && lw_bad == 0 && lpos_bad == 0, "R2 timing in sequence",
        hi_bad + lo_bad + lw_bad + lpos_bad, 0);
    chk(idle_bad == 0, "R3 data low when not shifting", idle_bad, 0);

    clr();
    tgt_sel = 1'b1; start = 1'b1; wr_go = 1'b1; wr_word = 32'h1111_1111; wr_latch = 1'b0;
    @(negedge clk); start = 1'b0; wr_go = 1'b0;
    repeat (300) @(negedge clk);
    chk(cap_n == 1 && caps[0] == r1, "R10 start wins over write", caps[0], r1);
    start = 1'b1; wr_go = 1'b1; wr_word = 32'hDEAD_BEEF; tgt_sel = 1'b0;
    @(negedge clk); start = 1'b0; wr_go = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(cap_n == 14 && done_n == 1, "R10 commands while busy ignored", cap_n, 14);
    chk(lb_n == 14 && la_n == 0, "R8 all latches on b", lb_n, 14);

    clr();
    wr_word = 32'hFFFF_FFFF; wr_latch = 1'b1; wr_go = 1'b1;
    @(negedge clk); wr_go = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !ser_data && !ser_clk && !latch_a && !latch_b, "R11 mid-transfer reset",
        {28'b0, busy, ser_data, ser_clk, latch_a}, 32'h0);
    repeat (400) @(negedge clk);
    chk(la_n == 0 && cap_n == 0, "R11 aborted word not latched", la_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule